// File: doc/BRIEF.md
# Packet Transmit Framer

This block assembles an outgoing radio packet as a stream of bytes for a downstream modulator. After a start strobe it emits a run of preamble bytes. It waits until the transmit FIFO holds data, then sends a 2- or 4-byte sync word. Next comes the payload, read from the FIFO. A 16-bit checksum can follow as two more bytes. The packet length comes either from a configuration input (fixed mode) or from the first FIFO byte (variable mode). Every byte after the sync word can be XORed with a pseudo-random whitening sequence.

The modulator side is a valid/ready byte handshake. The FIFO side is a show-ahead read port: the byte is visible whenever the empty flag is low, and it is consumed on a one-cycle read pulse. The modulator may ask for a payload byte while the FIFO is empty. The framer then locks into an underflow state. Only a flush strobe releases it, and bytes written to the FIFO later do not resume transmission. The configuration inputs must stay stable from start until the packet ends.

Top module: `pkt_tx_framer`

## Requirements
- R1: After reset the block is idle, with `tx_valid`, `fifo_rd`, `underflow`, `busy`, `sync_sent` and `pkt_done` all low.
- R2: After `start`, the block sends bytes of value 0xAA. It sends exactly `cfg_pre_len` of them when the FIFO already holds data. When the count is reached while the FIFO is empty, it keeps sending 0xAA and sends no sync byte until the FIFO is non-empty.
- R3: The sync word is sent most significant byte first. With `cfg_sync_4b`=1 that is all four bytes of `cfg_sync_word`. With `cfg_sync_4b`=0 it is only bits 15:0, and bits 31:16 are never sent. `sync_sent` pulses high for one cycle, in the cycle after the last sync byte is accepted.
- R4: With `cfg_var_len`=1, the first FIFO byte L is sent as the first byte after the sync word. Exactly L further FIFO bytes follow it. L=0 gives a packet with only the length byte.
- R5: With `cfg_var_len`=0, exactly `cfg_fix_len` FIFO bytes are sent (`cfg_fix_len` must be at least 1), and the first one is treated as ordinary payload.
- R6: With `cfg_crc_en`=1, two bytes follow the payload: high byte first, then low byte. They hold a CRC-16 over every raw byte read from the FIFO, length byte included. The CRC uses polynomial 0x8005 and initial value 0xFFFF, and takes each byte MSB first.
- R7: With `cfg_white_en`=1, every payload and CRC byte is XORed with bits 7:0 of a 9-bit register. The register is seeded to 0x1FF for the first byte after the sync word. Between bytes it takes 8 steps of `s = {s[0]^s[5], s[8:1]}`. Preamble and sync bytes are never whitened.
- R8: In the payload phase, if `tx_ready` is high while `fifo_empty` is high, the block enters underflow. There `underflow` is 1, `tx_valid` is 0 and no FIFO read occurs.
- R9: Underflow is left only through `flush`. New FIFO data and `start` strobes have no effect while in underflow. A flush returns the block to idle from any state.
- R10: `pkt_done` pulses for one cycle after the last byte of the packet is accepted, and the block is then idle. A `start` received while busy has no effect on the byte stream.
- R11: `fifo_rd` pulses only in a cycle where a payload byte is accepted (`tx_valid` and `tx_ready` high, `fifo_empty` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pre_len | input | PRE_W | Number of preamble bytes |
| cfg_sync_word | input | 32 | Sync word value |
| cfg_sync_4b | input | 1 | 1: four-byte sync, 0: two-byte sync |
| cfg_var_len | input | 1 | 1: length taken from first FIFO byte |
| cfg_fix_len | input | LEN_W | Payload length in fixed mode |
| cfg_crc_en | input | 1 | Append CRC-16 |
| cfg_white_en | input | 1 | Whiten bytes after the sync word |
| start | input | 1 | Begin a packet (idle only) |
| flush | input | 1 | Abort, clear underflow, return to idle |
| fifo_data | input | 8 | Head byte of the transmit FIFO |
| fifo_empty | input | 1 | FIFO holds no byte |
| fifo_rd | output | 1 | Pop the FIFO head |
| tx_data | output | 8 | Byte to the modulator |
| tx_valid | output | 1 | `tx_data` is offered |
| tx_ready | input | 1 | Modulator accepts a byte |
| sync_sent | output | 1 | One-cycle pulse after the sync word |
| pkt_done | output | 1 | One-cycle pulse after the final byte |
| underflow | output | 1 | Locked in the underflow state |
| busy | output | 1 | A packet is in progress |

## Verification
The bench targets the length byte of value zero and the two-byte sync mode. A design that mishandled the length byte would read one byte too many or too few. One that mishandled the short sync would leak the upper sync bits onto the stream. An empty FIFO after the preamble count is reached is another target: a wrong design would start the sync word early or run into underflow. For underflow, the bench writes fresh data and strobes start while the block is locked. A design that did not latch the error would drain the new bytes, and the bench sees that as FIFO reads and new output. CRC and whitening are checked byte for byte against a model built from the stated polynomials, under both steady and stalling `tx_ready`. This catches wrong seeds, wrong byte order, and a whitening sequence that moves on a stalled cycle.

// File: rtl/pkt_tx_pkg.sv
// Shared types, constants and byte-wise update functions for the packet
// transmit framer. Assumes 8-bit symbols on both the FIFO and modulator sides.
package pkt_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_SYNC,
        ST_PAY,
        ST_CRC,
        ST_UNDER
    } tx_state_e;

    localparam int          BYTE_W        = 8;
    localparam logic [7:0]  PREAMBLE_BYTE = 8'hAA;
    localparam logic [15:0] CRC_POLY      = 16'h8005;
    localparam logic [15:0] CRC_INIT      = 16'hFFFF;
    localparam logic [8:0]  PN9_SEED      = 9'h1FF;

    // One byte of CRC-16, most significant data bit first.
    function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                               input logic [7:0]  d);
        logic [15:0] c;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            if (c[15] ^ d[i]) c = {c[14:0], 1'b0} ^ CRC_POLY;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    // Eight steps of the x^9 + x^5 + 1 sequence generator.
    function automatic logic [8:0] pn9_adv8(input logic [8:0] s_in);
        logic [8:0] s;
        s = s_in;
        for (int i = 0; i < 8; i++) s = {s[0] ^ s[5], s[8:1]};
        return s;
    endfunction

endpackage

// File: rtl/pkt_tx_crc.sv
// Running CRC-16 register. Loads the initial value on init and folds in one
// byte per upd. Assumes init and upd are never high in the same cycle.
module pkt_tx_crc
    import pkt_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init,
    input  logic              upd,
    input  logic [BYTE_W-1:0] din,
    output logic [15:0]       crc
);
    // Hold, preset or advance the checksum.
    always_ff @(posedge clk) begin
        if (!rst_n)    crc <= CRC_INIT;
        else if (init) crc <= CRC_INIT;
        else if (upd)  crc <= crc16_byte(crc, din);
    end
endmodule

// File: rtl/pkt_tx_whiten.sv
// Whitening mask source. The mask for the current byte is the low byte of the
// generator state. The state moves 8 steps for each accepted byte.
module pkt_tx_whiten
    import pkt_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed,
    input  logic              adv,
    output logic [BYTE_W-1:0] mask
);
    logic [8:0] lfsr;

    // Reseed at the end of the sync word, step once per whitened byte.
    always_ff @(posedge clk) begin
        if (!rst_n)    lfsr <= PN9_SEED;
        else if (seed) lfsr <= PN9_SEED;
        else if (adv)  lfsr <= pn9_adv8(lfsr);
    end

    assign mask = lfsr[BYTE_W-1:0];
endmodule

// File: rtl/pkt_tx_framer.sv
// Packet transmit framer: preamble, sync word, payload from a show-ahead FIFO,
// optional CRC-16 and optional whitening, with underflow lock-out.
// Assumes the configuration inputs are stable for the whole packet, that
// LEN_W >= 8, and that cfg_fix_len >= 1 in fixed mode.
module pkt_tx_framer
    import pkt_tx_pkg::*;
#(
    parameter int PRE_W = 8,
    parameter int LEN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PRE_W-1:0]  cfg_pre_len,
    input  logic [31:0]       cfg_sync_word,
    input  logic              cfg_sync_4b,
    input  logic              cfg_var_len,
    input  logic [LEN_W-1:0]  cfg_fix_len,
    input  logic              cfg_crc_en,
    input  logic              cfg_white_en,
    input  logic              start,
    input  logic              flush,
    input  logic [BYTE_W-1:0] fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              sync_sent,
    output logic              pkt_done,
    output logic              underflow,
    output logic              busy
);
    localparam logic [PRE_W-1:0] PRE_MAX = '1;
    localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

    tx_state_e         state;
    logic [PRE_W-1:0]  pre_cnt;
    logic [1:0]        sync_idx;
    logic              len_pend;
    logic [LEN_W-1:0]  left;
    logic              crc_idx;

    logic              fire, pre_done, sync_last, pay_last;
    logic [1:0]        sync_sel;
    logic [BYTE_W-1:0] sync_byte, wmask, wsel;
    logic [15:0]       crc_val;
    logic              crc_init, wh_adv;

    assign fire      = tx_valid && tx_ready;
    assign pre_done  = (pre_cnt >= cfg_pre_len);
    assign sync_last = (sync_idx == (cfg_sync_4b ? 2'd3 : 2'd1));
    assign sync_sel  = cfg_sync_4b ? (2'd3 - sync_idx) : (2'd1 - sync_idx);
    assign sync_byte = cfg_sync_word[{sync_sel, 3'b000} +: BYTE_W];
    assign pay_last  = len_pend ? (fifo_data == '0) : (left == LEN_ONE);
    assign wsel      = cfg_white_en ? wmask : '0;
    assign crc_init  = (state == ST_SYNC) && fire && sync_last;
    assign wh_adv    = fire && ((state == ST_PAY) || (state == ST_CRC));

    pkt_tx_crc i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (crc_init),
        .upd   (fifo_rd),
        .din   (fifo_data),
        .crc   (crc_val)
    );

    pkt_tx_whiten i_whiten (
        .clk   (clk),
        .rst_n (rst_n),
        .seed  (crc_init),
        .adv   (wh_adv),
        .mask  (wmask)
    );

    // Select the byte on offer and whether it is valid in this state.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = PREAMBLE_BYTE;
        unique case (state)
            ST_PRE:  tx_valid = !(pre_done && !fifo_empty);
            ST_SYNC: begin
                tx_valid = 1'b1;
                tx_data  = sync_byte;
            end
            ST_PAY: begin
                tx_valid = !fifo_empty;
                tx_data  = fifo_data ^ wsel;
            end
            ST_CRC: begin
                tx_valid = 1'b1;
                tx_data  = (crc_idx ? crc_val[7:0] : crc_val[15:8]) ^ wsel;
            end
            default: ;
        endcase
    end

    assign fifo_rd   = (state == ST_PAY) && fire;
    assign underflow = (state == ST_UNDER);
    assign busy      = (state != ST_IDLE);

    // Sequence the packet phases and produce the one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            pre_cnt   <= '0;
            sync_idx  <= '0;
            len_pend  <= 1'b0;
            left      <= '0;
            crc_idx   <= 1'b0;
            sync_sent <= 1'b0;
            pkt_done  <= 1'b0;
        end else begin
            sync_sent <= 1'b0;
            pkt_done  <= 1'b0;
            if (flush) begin
                state <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: if (start) begin
                        state   <= ST_PRE;
                        pre_cnt <= '0;
                    end
                    ST_PRE: begin
                        if (fire && pre_cnt != PRE_MAX) pre_cnt <= pre_cnt + 1'b1;
                        if (pre_done && !fifo_empty) begin
                            state    <= ST_SYNC;
                            sync_idx <= '0;
                        end
                    end
                    ST_SYNC: if (fire) begin
                        if (sync_last) begin
                            state     <= ST_PAY;
                            sync_sent <= 1'b1;
                            len_pend  <= cfg_var_len;
                            left      <= cfg_fix_len;
                        end else begin
                            sync_idx <= sync_idx + 1'b1;
                        end
                    end
                    ST_PAY: begin
                        if (fire) begin
                            len_pend <= 1'b0;
                            left     <= len_pend ? LEN_W'(fifo_data) : left - LEN_ONE;
                            if (pay_last) begin
                                if (cfg_crc_en) begin
                                    state   <= ST_CRC;
                                    crc_idx <= 1'b0;
                                end else begin
                                    state    <= ST_IDLE;
                                    pkt_done <= 1'b1;
                                end
                            end
                        end else if (tx_ready && fifo_empty) begin
                            state <= ST_UNDER;
                        end
                    end
                    ST_CRC: if (fire) begin
                        if (crc_idx) begin
                            state    <= ST_IDLE;
                            pkt_done <= 1'b1;
                        end else begin
                            crc_idx <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/pkt_tx_framer_chk.sv
// Protocol checker for the framer ports, attached by bind. It observes only
// and drives nothing.
module pkt_tx_framer_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic fifo_empty,
    input logic fifo_rd,
    input logic tx_valid,
    input logic tx_ready,
    input logic sync_sent,
    input logic pkt_done,
    input logic underflow,
    input logic busy
);
    p_rd_on_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> (tx_valid && tx_ready && !fifo_empty));

    p_under_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> (!tx_valid && !fifo_rd));

    p_under_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush) |=> underflow);

    p_flush_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !busy);

    p_sync_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sync_sent |=> !sync_sent);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |=> !pkt_done);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> (!busy && !sync_sent));
endmodule

bind pkt_tx_framer pkt_tx_framer_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .sync_sent  (sync_sent),
    .pkt_done   (pkt_done),
    .underflow  (underflow),
    .busy       (busy)
);

// File: tb/test_pkt_tx_framer.sv
`timescale 1ns/1ps
// Directed bench for pkt_tx_framer: one task per scenario, each checking itself.
module test_pkt_tx_framer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_pre_len = '0;
    logic [31:0] cfg_sync_word = '0;
    logic        cfg_sync_4b = 1'b0, cfg_var_len = 1'b0, cfg_crc_en = 1'b0, cfg_white_en = 1'b0;
    logic [7:0]  cfg_fix_len = 8'd1;
    logic        start = 1'b0, flush = 1'b0;
    logic [7:0]  fifo_data;
    logic        fifo_empty, fifo_rd;
    logic [7:0]  tx_data;
    logic        tx_valid, tx_ready = 1'b1;
    logic        sync_sent, pkt_done, underflow, busy;

    always #4 clk = ~clk;

    // FIFO model: show-ahead, popped on fifo_rd.
    logic [7:0]  fmem [0:63];
    int unsigned fhead = 0, ftail = 0;
    assign fifo_empty = (fhead == ftail);
    assign fifo_data  = fmem[fhead % 64];
    always @(posedge clk) if (fifo_rd) fhead <= fhead + 1;

    pkt_tx_framer i_pkt_tx_framer (.*);

    int checks = 0, fails = 0, cyc = 0;
    int ready_mode = 0;
    logic [7:0] cap [0:511];
    int ncap = 0, nsync = 0, sync_at = -1, ndone = 0;
    logic [7:0] expb [0:255];
    int nexp = 0;
    logic [7:0] src [0:63];
    int nsrc = 0;

    // Drive ready, then record events and accepted bytes between edges.
    always @(negedge clk) begin
        cyc++;
        tx_ready = (ready_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
        if (sync_sent) begin nsync++; sync_at = ncap; end
        if (pkt_done) ndone++;
        if (tx_valid && tx_ready && ncap < 512) begin cap[ncap] = tx_data; ncap++; end
    end

    // Watchdog.
    initial begin
        #1_000_000;
        fails++; checks++;
        $display("FAIL watchdog: act=timeout exp=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d (0x%0h) exp=%0d (0x%0h)", tag, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[15] ^ d[i];
            c  = c << 1;
            if (fb) c = c ^ 16'h8005;
        end
        return c;
    endfunction

    function automatic logic [8:0] m_pn9(input logic [8:0] s);
        for (int i = 0; i < 8; i++) s = {s[0] ^ s[5], s[8:1]};
        return s;
    endfunction

    // Expected stream from the requirements; pre < 0 omits the preamble.
    task automatic build(input int pre);
        logic [15:0] c;
        logic [8:0]  s;
        logic [7:0]  m;
        nexp = 0; c = 16'hFFFF; s = 9'h1FF;
        for (int i = 0; i < pre; i++) begin expb[nexp] = 8'hAA; nexp++; end
        for (int i = (cfg_sync_4b ? 3 : 1); i >= 0; i--) begin
            expb[nexp] = cfg_sync_word[i*8 +: 8]; nexp++;
        end
        for (int i = 0; i < nsrc; i++) begin
            c = m_crc(c, src[i]);
            m = cfg_white_en ? s[7:0] : 8'h00;
            expb[nexp] = src[i] ^ m; nexp++;
            s = m_pn9(s);
        end
        if (cfg_crc_en) begin
            m = cfg_white_en ? s[7:0] : 8'h00;
            expb[nexp] = c[15:8] ^ m; nexp++;
            s = m_pn9(s);
            m = cfg_white_en ? s[7:0] : 8'h00;
            expb[nexp] = c[7:0] ^ m; nexp++;
        end
    endtask

    task automatic push_src();
        for (int i = 0; i < nsrc; i++) begin fmem[ftail % 64] = src[i]; ftail++; end
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic clear_cap();
        ncap = 0; nsync = 0; sync_at = -1; ndone = 0;
    endtask

    task automatic wait_done(input int limit);
        for (int t = 0; t < limit && ndone == 0; t++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Compare the captured tail with the expected list.
    task automatic cmp_tail(input string tag);
        int bad, first, off;
        bad = 0; first = -1; off = ncap - nexp;
        for (int i = 0; i < nexp; i++)
            if (off + i < 0 || cap[off + i] !== expb[i]) begin
                bad++; if (first < 0) first = i;
            end
        chk(bad == 0, tag, (first < 0) ? 0 : int'(cap[off + first]),
            (first < 0) ? 0 : int'(expb[first]));
    endtask

    task automatic t_reset();
        chk(!tx_valid && !fifo_rd && !underflow && !busy && !sync_sent && !pkt_done,
            "R1 idle after reset", {tx_valid, fifo_rd, underflow, busy}, 0);
    endtask

    task automatic t_packet(input string tag, input int pre, input bit s4,
                            input logic [31:0] sw, input bit vl, input int flen,
                            input bit crc, input bit wh, input int rmode, input bit mid_start);
        cfg_pre_len = pre[7:0]; cfg_sync_4b = s4; cfg_sync_word = sw; cfg_var_len = vl;
        cfg_fix_len = flen[7:0]; cfg_crc_en = crc; cfg_white_en = wh; ready_mode = rmode;
        push_src();
        build(pre);
        clear_cap();
        pulse_start();
        if (mid_start) begin repeat (6) @(negedge clk); pulse_start(); end
        wait_done(3000);
        chk(ncap == nexp, {tag, " byte count"}, ncap, nexp);
        cmp_tail({tag, " byte stream"});
        chk(nsync == 1 && sync_at == pre + (s4 ? 4 : 2), "R3 sync_sent pulse position",
            sync_at, pre + (s4 ? 4 : 2));
        chk(ndone == 1 && !busy, "R10 done pulse and idle", ndone, 1);
        chk(fifo_empty, {tag, " all FIFO bytes consumed"}, ftail - fhead, 0);
        ready_mode = 0;
    endtask

    task automatic t_late_data();
        int aa;
        cfg_pre_len = 8'd3; cfg_sync_4b = 1'b1; cfg_sync_word = 32'h1234_5678;
        cfg_var_len = 1'b1; cfg_crc_en = 1'b0; cfg_white_en = 1'b0;
        clear_cap();
        pulse_start();
        repeat (30) @(negedge clk);
        aa = 0;
        for (int i = 0; i < ncap; i++) if (cap[i] == 8'hAA) aa++;
        chk(ncap >= 20 && aa == ncap && nsync == 0 && !underflow,
            "R2 preamble continues while FIFO empty", aa, ncap);
        src[0] = 8'd2; src[1] = 8'h09; src[2] = 8'h08; nsrc = 3;
        push_src();
        build(-1);
        wait_done(500);
        cmp_tail("R2 R4 sync and payload after late data");
        chk(sync_at == ncap - nexp + 4 && ndone == 1, "R2 sync follows data", sync_at, ncap - nexp + 4);
    endtask

    task automatic t_underflow();
        int n0, fill;
        cfg_pre_len = 8'd1; cfg_sync_4b = 1'b0; cfg_sync_word = 32'h0000_C3A5;
        cfg_var_len = 1'b1; cfg_crc_en = 1'b1; cfg_white_en = 1'b0;
        src[0] = 8'd6; src[1] = 8'h01; src[2] = 8'h02; src[3] = 8'h03; nsrc = 4;
        push_src();
        clear_cap();
        pulse_start();
        repeat (40) @(negedge clk);
        chk(underflow && !tx_valid && busy, "R8 underflow entered", underflow, 1);
        chk(ncap == 1 + 2 + 4 && ndone == 0, "R8 bytes before underflow", ncap, 7);
        n0 = ncap;
        for (int i = 0; i < 5; i++) begin fmem[ftail % 64] = 8'h50 + i[7:0]; ftail++; end
        pulse_start();
        repeat (20) @(negedge clk);
        fill = ftail - fhead;
        chk(underflow && fill == 5 && ncap == n0, "R9 refill and start ignored in underflow", fill, 5);
        @(negedge clk) begin flush = 1'b1; ftail = fhead; end
        @(negedge clk) flush = 1'b0;
        @(negedge clk);
        chk(!underflow && !busy, "R9 flush releases underflow", {underflow, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();

        // R4 R6 R7: variable length with address, CRC and whitening, 4-byte sync.
        src[0] = 8'd5; src[1] = 8'h3C; src[2] = 8'hA1; src[3] = 8'h00; src[4] = 8'hFF; src[5] = 8'h7E;
        nsrc = 6;
        t_packet("R4 R6 R7 var crc white", 4, 1'b1, 32'hD391_D391, 1'b1, 0, 1'b1, 1'b1, 0, 1'b0);

        // R3 R5: fixed length, two-byte sync with junk in bits 31:16.
        for (int i = 0; i < 6; i++) src[i] = 8'h10 * i[7:0] + 8'h1;
        nsrc = 6;
        t_packet("R3 R5 fixed short sync", 2, 1'b0, 32'hEEEE_2DD4, 1'b0, 6, 1'b0, 1'b0, 0, 1'b0);

        // R4 R6: length byte of zero, CRC only over the length byte.
        src[0] = 8'd0; nsrc = 1;
        t_packet("R4 R6 zero length", 1, 1'b1, 32'h0102_0304, 1'b1, 0, 1'b1, 1'b0, 0, 1'b0);

        // R2 R5 R7: no preamble, fixed length, whitening, stalling ready.
        src[0] = 8'hC0; src[1] = 8'h01; src[2] = 8'h5A; nsrc = 3;
        t_packet("R2 R5 R7 stall", 0, 1'b1, 32'hCAFE_F00D, 1'b0, 3, 1'b0, 1'b1, 1, 1'b0);

        // R6 R7 R10: longer variable packet under stalls with a start while busy.
        src[0] = 8'd10;
        for (int i = 1; i <= 10; i++) src[i] = 8'h21 * i[7:0];
        nsrc = 11;
        t_packet("R6 R7 R10 long stall", 3, 1'b0, 32'h0000_7E81, 1'b1, 0, 1'b1, 1'b1, 1, 1'b1);

        t_late_data();
        t_underflow();

        // R9 R10: normal packet after recovery.
        src[0] = 8'd2; src[1] = 8'h44; src[2] = 8'h55; nsrc = 3;
        t_packet("R9 R10 after flush", 2, 1'b1, 32'hA5A5_0F0F, 1'b1, 0, 1'b1, 1'b1, 0, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule